// File: doc/BRIEF.md
# Victim Line Buffer

This block sits between a first-level cache and a second-level cache and holds a handful of whole lines that the first level has just evicted. An eviction is written here instead of going straight to the second level. The write to the second level is therefore off the critical path of the miss that caused the eviction, and the second-level read for that miss can start at once. On every first-level miss the buffer is searched over all of its entries in the same cycle. A match returns the line far sooner than a second-level access. The matching entry then leaves the buffer, so a line is never held by both this buffer and the first level.

Once the last free slot is taken, the buffer empties itself into the second level, oldest entry first, over a valid/ready port. During that flush it refuses new evictions by holding its push-ready output low. Lookups still search the entries that have not yet gone out.

The controller has two states. `ST_FILL` accepts evictions. `ST_DRAIN` sends entries to the second level. The transition FILL→DRAIN is taken on the clock edge at which the store becomes full. The transition DRAIN→FILL is taken on the edge at which the store becomes empty, whether the last entry left through the drain port or through a lookup hit.

Top module: `victim_buffer`

## Requirements
- R1: After reset the buffer is empty, `evict_ready` is 1, `flush_valid` is 0, and no lookup hits.
- R2: A line accepted on the eviction port (`evict_valid` and `evict_ready` both 1 at a clock edge) can be found from the next cycle on. A lookup of its address then gives `probe_hit`=1 and `probe_line` equal to the pushed data, in the same cycle as the request.
- R3: A lookup that hits removes that entry, so a later lookup of the same address misses.
- R4: A lookup that misses leaves the contents unchanged, and every stored line is still found afterwards.
- R5: In the cycle after the edge that stores the DEPTH-th line, `evict_ready` is 0 and `flush_valid` is 1. `evict_ready` stays 0 for as long as the flush lasts.
- R6: Entries leave through the flush port in the order they were pushed. Entries already removed by lookup hits are skipped.
- R7: While `flush_valid` is 1 and `flush_ready` is 0 (and no lookup takes the head), `flush_addr` and `flush_line` hold their values.
- R8: During a flush, lookups still hit entries not yet flushed. Lines already flushed miss.
- R9: If a lookup hits the oldest entry while a flush is in progress, the lookup takes the line and `flush_valid` is 0 in that cycle. The line is never sent to the second level.
- R10: In the cycle after the edge that removes the last entry, `evict_ready` is 1 and `flush_valid` is 0.
- R11: A push and a lookup hit in the same cycle both take effect: the hit line is removed and the pushed line is stored.
- R12: At most one entry matches any lookup address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evict_valid | input | 1 | Eviction push request |
| evict_addr | input | AW | Line address of evicted line |
| evict_line | input | DW | Data of evicted line |
| evict_ready | output | 1 | Push accepted when high |
| probe_valid | input | 1 | Lookup request on first-level miss |
| probe_addr | input | AW | Line address searched |
| probe_hit | output | 1 | Lookup matched a buffered line |
| probe_line | output | DW | Data of matching line |
| flush_valid | output | 1 | Oldest entry offered to second level |
| flush_addr | output | AW | Address of offered line |
| flush_line | output | DW | Data of offered line |
| flush_ready | input | 1 | Second level accepts offered line |

## Verification
The bench goes after four cases.

- A lookup hit in the middle of the age order. A store that compacted wrongly would drain lines out of order or repeat one.
- A push and a hit in the same cycle. A design that served only one of them would lose a line or keep a stale copy, breaking exclusivity.
- A lookup that takes the head entry while the second level is also ready. A design that got this wrong would send the line both to the first level and to the second level.
- The edges where the buffer fills and empties. An off-by-one there would accept a ninth push, or leave `evict_ready` low forever.

// File: rtl/vb_pkg.sv
package vb_pkg;
    typedef enum logic {
        ST_FILL  = 1'b0,
        ST_DRAIN = 1'b1
    } vb_state_e;
endpackage

// File: rtl/vb_match.sv
// Fully associative search over all valid entries.
module vb_match #(
    parameter int DEPTH = 8,
    parameter int AW    = 26,
    parameter int DW    = 64
) (
    input  logic [DEPTH-1:0][AW-1:0] ent_addr,
    input  logic [DEPTH-1:0][DW-1:0] ent_data,
    input  logic [DEPTH-1:0]         ent_vld,
    input  logic [AW-1:0]            key,
    output logic [DEPTH-1:0]         match_vec,
    output logic                     any_match,
    output logic [DW-1:0]            match_data
);
    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_cmp
            assign match_vec[gi] = ent_vld[gi] && (ent_addr[gi] == key);
        end
    endgenerate

    assign any_match = |match_vec;

    // one-hot AND-OR mux of the line data
    always_comb begin
        match_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match_vec[i]) begin
                match_data = match_data | ent_data[i];
            end
        end
    end
endmodule

// File: rtl/vb_store.sv
// Entry storage kept in age order: slot 0 is the oldest. Removed entries are
// squeezed out and a new push is appended after the survivors.
module vb_store #(
    parameter int DEPTH = 8,
    parameter int AW    = 26,
    parameter int DW    = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push_en,
    input  logic [AW-1:0]            push_addr,
    input  logic [DW-1:0]            push_data,
    input  logic [DEPTH-1:0]         rm_mask,
    output logic [DEPTH-1:0][AW-1:0] ent_addr,
    output logic [DEPTH-1:0][DW-1:0] ent_data,
    output logic [DEPTH-1:0]         ent_vld,
    output logic                     nxt_full,
    output logic                     nxt_empty
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0][AW-1:0] n_addr;
    logic [DEPTH-1:0][DW-1:0] n_data;
    logic [DEPTH-1:0]         n_vld;
    logic [CW-1:0]            wr_pos;

    always_comb begin
        n_addr = ent_addr;
        n_data = ent_data;
        n_vld  = '0;
        wr_pos = '0;
        for (int j = 0; j < DEPTH; j++) begin
            if (ent_vld[j] && !rm_mask[j]) begin
                n_addr[wr_pos[IW-1:0]] = ent_addr[j];
                n_data[wr_pos[IW-1:0]] = ent_data[j];
                n_vld[wr_pos[IW-1:0]]  = 1'b1;
                wr_pos = wr_pos + 1'b1;
            end
        end
        if (push_en && (wr_pos < CW'(DEPTH))) begin
            n_addr[wr_pos[IW-1:0]] = push_addr;
            n_data[wr_pos[IW-1:0]] = push_data;
            n_vld[wr_pos[IW-1:0]]  = 1'b1;
        end
    end

    assign nxt_full  = n_vld[DEPTH-1];
    assign nxt_empty = !n_vld[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_vld <= '0;
        end else begin
            ent_vld <= n_vld;
        end
    end

    always_ff @(posedge clk) begin
        ent_addr <= n_addr;
        ent_data <= n_data;
    end
endmodule

// File: rtl/vb_ctrl.sv
// Fill/drain controller.
module vb_ctrl
    import vb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic push_req,
    input  logic head_vld,
    input  logic head_taken,
    input  logic drain_rdy,
    input  logic nxt_full,
    input  logic nxt_empty,
    output logic push_rdy,
    output logic push_en,
    output logic drain_vld,
    output logic pop_head
);
    vb_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL:  if (nxt_full)  state_d = ST_DRAIN;
            ST_DRAIN: if (nxt_empty) state_d = ST_FILL;
            default:  state_d = ST_FILL;
        endcase
    end

    // outputs
    always_comb begin
        push_rdy  = 1'b0;
        drain_vld = 1'b0;
        unique case (state_q)
            ST_FILL:  push_rdy  = 1'b1;
            ST_DRAIN: drain_vld = head_vld && !head_taken;
            default: begin
                push_rdy  = 1'b0;
                drain_vld = 1'b0;
            end
        endcase
        push_en  = push_req && push_rdy;
        pop_head = drain_vld && drain_rdy;
    end
endmodule

// File: rtl/victim_buffer.sv
module victim_buffer #(
    parameter int DEPTH = 8,
    parameter int AW    = 26,
    parameter int DW    = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evict_valid,
    input  logic [AW-1:0] evict_addr,
    input  logic [DW-1:0] evict_line,
    output logic          evict_ready,
    input  logic          probe_valid,
    input  logic [AW-1:0] probe_addr,
    output logic          probe_hit,
    output logic [DW-1:0] probe_line,
    output logic          flush_valid,
    output logic [AW-1:0] flush_addr,
    output logic [DW-1:0] flush_line,
    input  logic          flush_ready
);
    logic [DEPTH-1:0][AW-1:0] ent_addr;
    logic [DEPTH-1:0][DW-1:0] ent_data;
    logic [DEPTH-1:0]         ent_vld;
    logic [DEPTH-1:0]         match_vec;
    logic [DEPTH-1:0]         hit_vec;
    logic [DEPTH-1:0]         rm_mask;
    logic                     any_match;
    logic                     nxt_full;
    logic                     nxt_empty;
    logic                     push_en;
    logic                     pop_head;

    vb_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_match (
        .ent_addr  (ent_addr),
        .ent_data  (ent_data),
        .ent_vld   (ent_vld),
        .key       (probe_addr),
        .match_vec (match_vec),
        .any_match (any_match),
        .match_data(probe_line)
    );

    assign probe_hit = probe_valid && any_match;
    assign hit_vec   = probe_valid ? match_vec : '0;
    assign rm_mask   = hit_vec | {{(DEPTH-1){1'b0}}, pop_head};

    vb_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (evict_valid),
        .head_vld  (ent_vld[0]),
        .head_taken(hit_vec[0]),
        .drain_rdy (flush_ready),
        .nxt_full  (nxt_full),
        .nxt_empty (nxt_empty),
        .push_rdy  (evict_ready),
        .push_en   (push_en),
        .drain_vld (flush_valid),
        .pop_head  (pop_head)
    );

    vb_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_en  (push_en),
        .push_addr(evict_addr),
        .push_data(evict_line),
        .rm_mask  (rm_mask),
        .ent_addr (ent_addr),
        .ent_data (ent_data),
        .ent_vld  (ent_vld),
        .nxt_full (nxt_full),
        .nxt_empty(nxt_empty)
    );

    assign flush_addr = ent_addr[0];
    assign flush_line = ent_data[0];
endmodule

// File: rtl/vb_checker.sv
module vb_checker #(
    parameter int DEPTH = 8,
    parameter int AW    = 26,
    parameter int DW    = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             evict_valid,
    input logic [AW-1:0]    evict_addr,
    input logic             evict_ready,
    input logic             probe_valid,
    input logic [AW-1:0]    probe_addr,
    input logic             probe_hit,
    input logic             flush_valid,
    input logic [AW-1:0]    flush_addr,
    input logic [DW-1:0]    flush_line,
    input logic             flush_ready,
    input logic [DEPTH-1:0] match_vec
);
    assert_single_match_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

    assert_no_push_in_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> !evict_ready);

    assert_enter_flush_on_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(evict_ready) |-> $past(evict_valid && evict_ready));

    assert_flush_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid && !flush_ready && !probe_valid) |=>
            ($stable(flush_addr) && $stable(flush_line)));

    assert_hit_removes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        probe_hit |=> !(probe_valid && probe_hit && probe_addr == $past(probe_addr)
                        && !($past(evict_valid && evict_ready)
                             && $past(evict_addr) == probe_addr)));

    assert_hit_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        probe_hit |-> probe_valid);
endmodule

bind victim_buffer vb_checker #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_vb_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evict_valid(evict_valid),
    .evict_addr (evict_addr),
    .evict_ready(evict_ready),
    .probe_valid(probe_valid),
    .probe_addr (probe_addr),
    .probe_hit  (probe_hit),
    .flush_valid(flush_valid),
    .flush_addr (flush_addr),
    .flush_line (flush_line),
    .flush_ready(flush_ready),
    .match_vec  (match_vec)
);

// File: tb/tb_victim_buffer.sv
`timescale 1ns/1ps
module tb_victim_buffer;
    localparam int DEPTH = 8;
    localparam int AW    = 26;
    localparam int DW    = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          evict_valid = 1'b0;
    logic [AW-1:0] evict_addr = '0;
    logic [DW-1:0] evict_line = '0;
    logic          evict_ready;
    logic          probe_valid = 1'b0;
    logic [AW-1:0] probe_addr = '0;
    logic          probe_hit;
    logic [DW-1:0] probe_line;
    logic          flush_valid;
    logic [AW-1:0] flush_addr;
    logic [DW-1:0] flush_line;
    logic          flush_ready = 1'b0;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    victim_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut (.*);

    function automatic logic [DW-1:0] line_of(input logic [AW-1:0] a);
        logic [31:0] lo;
        lo = 32'(a) * 32'd7 + 32'h1357;
        return {6'h2A, a, lo};
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive at negedge, check combinational outputs, then complete the edge
    task automatic step_push(input logic [AW-1:0] a);
        evict_valid = 1'b1; evict_addr = a; evict_line = line_of(a);
        @(negedge clk);
        evict_valid = 1'b0;
    endtask

    task automatic step_probe(input string req, input logic [AW-1:0] a, input logic exp_hit);
        probe_valid = 1'b1; probe_addr = a;
        #2;
        check(req, DW'(probe_hit), DW'(exp_hit));
        if (exp_hit) check(req, probe_line, line_of(a));
        @(negedge clk);
        probe_valid = 1'b0;
    endtask

    // op(1) : 0 push, 1 probe | addr(26) | expected hit(1)
    localparam int NV = 9;
    localparam logic [27:0] VEC [NV] = '{
        {1'b0, 26'd10, 1'b0},
        {1'b0, 26'd11, 1'b0},
        {1'b0, 26'd12, 1'b0},
        {1'b1, 26'd11, 1'b1},
        {1'b1, 26'd11, 1'b0},
        {1'b1, 26'd99, 1'b0},
        {1'b1, 26'd10, 1'b1},
        {1'b1, 26'd12, 1'b1},
        {1'b1, 26'd12, 1'b0}
    };

    initial begin
        #(200000 * 20);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1 reset state
        check("R1", DW'(evict_ready), 1);
        check("R1", DW'(flush_valid), 0);
        probe_valid = 1'b1; probe_addr = 26'd10; #1;
        check("R1", DW'(probe_hit), 0);
        probe_valid = 1'b0;
        @(negedge clk);

        // table walk: R2 push-then-find, R3 hit removes, R4 miss keeps
        for (int k = 0; k < NV; k++) begin
            if (VEC[k][27] == 1'b0) step_push(VEC[k][26:1]);
            else step_probe((k == 5 || k == 6) ? "R4" : (k == 4 || k == 8) ? "R3" : "R2",
                            VEC[k][26:1], VEC[k][0]);
        end

        // R11 push and hit in the same cycle
        step_push(26'd21);
        evict_valid = 1'b1; evict_addr = 26'd22; evict_line = line_of(26'd22);
        step_probe("R11", 26'd21, 1'b1);
        evict_valid = 1'b0;
        step_probe("R11", 26'd22, 1'b1);
        step_probe("R11", 26'd21, 1'b0);

        // fill with 8 lines
        for (int k = 0; k < DEPTH; k++) begin
            #2;
            check("R5", DW'(evict_ready), 1);
            step_push(AW'(100 + k));
        end
        #2;
        // R5 drain started, pushes refused
        check("R5", DW'(evict_ready), 0);
        check("R5", DW'(flush_valid), 1);
        check("R6", DW'(flush_addr), DW'(100));
        // R7 hold while not ready
        @(negedge clk); #2;
        check("R7", DW'(flush_valid), 1);
        check("R7", DW'(flush_addr), DW'(100));
        check("R7", flush_line, line_of(26'd100));
        @(negedge clk);
        // R8 lookup of an entry not yet drained
        step_probe("R8", 26'd103, 1'b1);
        // R9 lookup takes the head while the second level is ready
        flush_ready = 1'b1;
        probe_valid = 1'b1; probe_addr = 26'd100; #2;
        check("R9", DW'(probe_hit), 1);
        check("R9", DW'(flush_valid), 0);
        @(negedge clk);
        probe_valid = 1'b0;
        // R6 remaining order, skipping the two removed lines
        begin
            logic [AW-1:0] order [6];
            order = '{26'd101, 26'd102, 26'd104, 26'd105, 26'd106, 26'd107};
            for (int k = 0; k < 6; k++) begin
                #2;
                check("R6", DW'(flush_valid), 1);
                check("R6", DW'(flush_addr), DW'(order[k]));
                check("R6", flush_line, line_of(order[k]));
                check("R5", DW'(evict_ready), 0);
                if (k == 1) begin
                    // R8 an already flushed line misses
                    probe_valid = 1'b1; probe_addr = 26'd101; #1;
                    check("R8", DW'(probe_hit), 0);
                    probe_valid = 1'b0;
                end
                @(negedge clk);
            end
        end
        flush_ready = 1'b0;
        #2;
        // R10 back to accepting
        check("R10", DW'(evict_ready), 1);
        check("R10", DW'(flush_valid), 0);
        @(negedge clk);
        step_push(26'd300);
        step_probe("R10", 26'd300, 1'b1);

        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule